// File: doc/BRIEF.md
# Interrupt translation command processor

This block takes 256-bit command words. Each one writes a set of small on-chip translation tables in a single clock. The tables map a device to a valid flag and an event-range size, a collection to a target address, and a (device, event) pair to a physical interrupt ID and a collection. A separate lookup port turns a (device, event) pair into an interrupt ID and the target address of its collection. A synchronisation command produces a one-cycle completion strobe that carries the target address named in the command.

Software or a queue-fetch engine presents at most one command per cycle on `cmd_valid`/`cmd_word`. The block has no back-pressure. Commands that are malformed, that name entries that do not exist, or that carry an unknown opcode change no table state. Instead they set a sticky error flag, which only reset clears. The number of devices, collections and events per device are parameters, and every table is held in flops.

Top module: `irq_xlate_engine`

## Requirements
- R1: `cmd_word[64k+63:64k]` holds doubleword k, with doubleword 0 at the lowest bits. The fields are as follows. Opcode is dw0[7:0]. Device ID is dw0[63:32]. Event ID is dw1[31:0]. Physical ID is dw1[63:32]. Size is dw1[4:0]. Collection ID is dw2[15:0]. Target is dw2[47:16]. The valid flag is dw2[63]. The opcodes are 0x08 device-map, 0x09 collection-map, 0x0B event-map, 0x01 event-move, 0x0F event-drop, 0x0C invalidate-one, 0x0D invalidate-collection and 0x05 sync.
- R2: Device-map with valid=1 maps the device with 2^(size+1) event slots. With valid=0 it unmaps the device. Either form clears every event mapping of that device. A device ID of 2^DEV_BITS or more sets the error flag.
- R3: Collection-map with valid=1 binds the collection to the target, and with valid=0 unbinds it. A collection ID of 2^COL_BITS or more sets the error flag.
- R4: Event-map binds (device, event) to the physical ID and the collection. This takes effect only if the device is mapped, the event is below both the device's slot count and 2^EVT_BITS, and the collection ID is in range. Otherwise the error flag is set and nothing changes.
- R5: Event-move changes the collection of a mapped event. On an unmapped event or an out-of-range collection it sets the error flag instead.
- R6: Event-drop removes a mapped event. On an unmapped event it sets the error flag instead.
- R7: Invalidate-one and invalidate-collection change no table and set no error.
- R8: Sync drives `sync_pulse` high for exactly the cycle after the command, with `sync_target` equal to dw2[47:16].
- R9: Any other opcode sets the error flag and has no other effect. The flag stays set until reset.
- R10: `lk_rsp_valid` answers a lookup one cycle after `lk_valid`. The response is a hit only when all of these hold: the device is mapped, the event is below its slot count, the event is mapped, and the event's collection is bound. On a miss, `lk_intid` and `lk_target` are 0.
- R11: A command takes effect for lookups requested in the following cycle. A lookup requested in the same cycle as the command sees the tables as they were before it.
- R12: After reset every table is empty and the error flag, `sync_pulse` and `lk_rsp_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_word | input | 256 | Four little-endian doublewords of the command |
| lk_valid | input | 1 | Lookup request |
| lk_dev | input | 32 | Lookup device ID |
| lk_evt | input | 32 | Lookup event ID |
| lk_rsp_valid | output | 1 | Lookup response present |
| lk_hit | output | 1 | Translation found |
| lk_intid | output | 32 | Physical interrupt ID, 0 on miss |
| lk_target | output | 32 | Target address of the collection, 0 on miss |
| sync_pulse | output | 1 | Sync completion strobe |
| sync_target | output | 32 | Target address of the last sync |
| err_flag | output | 1 | Sticky command error |

## Verification
A wrong table entry shows up only when a lookup touches it. It appears one cycle later as a false hit, a false miss, or the wrong ID or target. For this reason the bench follows every command with lookups that exercise both the entry that was written and the entries next to it. A wrongly accepted or rejected command shows on `err_flag` in the very next cycle. The bench resets between error cases so that each rejection is seen on its own. A lost or misplaced sync appears on `sync_pulse` in the cycle after the command.

// File: rtl/irq_xlate_engine.sv
module irq_xlate_engine #(
  parameter int DEV_BITS = 3,
  parameter int COL_BITS = 3,
  parameter int EVT_BITS = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmd_valid,
  input  logic [255:0] cmd_word,
  input  logic         lk_valid,
  input  logic [31:0]  lk_dev,
  input  logic [31:0]  lk_evt,
  output logic         lk_rsp_valid,
  output logic         lk_hit,
  output logic [31:0]  lk_intid,
  output logic [31:0]  lk_target,
  output logic         sync_pulse,
  output logic [31:0]  sync_target,
  output logic         err_flag
);
  localparam int NDEV  = 1 << DEV_BITS;
  localparam int NCOL  = 1 << COL_BITS;
  localparam int EIX_W = DEV_BITS + EVT_BITS;
  localparam int NEVT  = 1 << EIX_W;

  localparam logic [7:0] OP_DEV_MAP  = 8'h08;
  localparam logic [7:0] OP_COL_MAP  = 8'h09;
  localparam logic [7:0] OP_EVT_MAP  = 8'h0B;
  localparam logic [7:0] OP_EVT_MOVE = 8'h01;
  localparam logic [7:0] OP_EVT_DROP = 8'h0F;
  localparam logic [7:0] OP_INV_ONE  = 8'h0C;
  localparam logic [7:0] OP_INV_COL  = 8'h0D;
  localparam logic [7:0] OP_SYNC     = 8'h05;

  logic                dev_v   [NDEV];
  logic [4:0]          dev_sz  [NDEV];
  logic                col_v   [NCOL];
  logic [31:0]         col_tgt [NCOL];
  logic [NEVT-1:0]     ev_v;
  logic [31:0]         ev_pid  [NEVT];
  logic [COL_BITS-1:0] ev_col  [NEVT];

  function automatic logic in_size(input logic [31:0] evt, input logic [4:0] sz);
    logic [5:0] sh;
    sh = {1'b0, sz} + 6'd1;
    return (sh >= 6'd32) || ((evt >> sh) == 32'd0);
  endfunction

  // command fields
  wire [7:0]  op    = cmd_word[7:0];
  wire [31:0] c_dev = cmd_word[63:32];
  wire [31:0] c_evt = cmd_word[95:64];
  wire [31:0] c_pid = cmd_word[127:96];
  wire [4:0]  c_sz  = cmd_word[68:64];
  wire [15:0] c_col = cmd_word[143:128];
  wire [31:0] c_tgt = cmd_word[175:144];
  wire        c_vld = cmd_word[191];
  logic unused_bits;
  assign unused_bits = ^{cmd_word[255:192], cmd_word[190:176], cmd_word[31:8]};

  wire                dev_ok = (c_dev >> DEV_BITS) == 32'd0;
  wire                col_ok = (c_col >> COL_BITS) == 16'd0;
  wire                cap_ok = (c_evt >> EVT_BITS) == 32'd0;
  wire [DEV_BITS-1:0] d_ix   = c_dev[DEV_BITS-1:0];
  wire [COL_BITS-1:0] c_ix   = c_col[COL_BITS-1:0];
  wire [EIX_W-1:0]    e_ix   = {d_ix, c_evt[EVT_BITS-1:0]};
  wire                ev_live = dev_ok && cap_ok && ev_v[e_ix];

  logic bad;
  always_comb begin
    case (op)
      OP_DEV_MAP:  bad = !dev_ok;
      OP_COL_MAP:  bad = !col_ok;
      OP_EVT_MAP:  bad = !(dev_ok && dev_v[d_ix] && cap_ok && in_size(c_evt, dev_sz[d_ix]) && col_ok);
      OP_EVT_MOVE: bad = !(ev_live && col_ok);
      OP_EVT_DROP: bad = !ev_live;
      OP_INV_ONE, OP_INV_COL, OP_SYNC: bad = 1'b0;
      default:     bad = 1'b1;
    endcase
  end
  wire go = cmd_valid && !bad;

  // lookup path
  wire                l_dok = (lk_dev >> DEV_BITS) == 32'd0;
  wire                l_cap = (lk_evt >> EVT_BITS) == 32'd0;
  wire [DEV_BITS-1:0] l_dix = lk_dev[DEV_BITS-1:0];
  wire [EIX_W-1:0]    l_eix = {l_dix, lk_evt[EVT_BITS-1:0]};
  wire l_hit = l_dok && l_cap && dev_v[l_dix] && in_size(lk_evt, dev_sz[l_dix])
               && ev_v[l_eix] && col_v[ev_col[l_eix]];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NDEV; i++) begin dev_v[i] <= 1'b0; dev_sz[i] <= '0; end
      for (int i = 0; i < NCOL; i++) begin col_v[i] <= 1'b0; col_tgt[i] <= '0; end
      for (int i = 0; i < NEVT; i++) begin ev_pid[i] <= '0; ev_col[i] <= '0; end
      ev_v         <= '0;
      err_flag     <= 1'b0;
      sync_pulse   <= 1'b0;
      sync_target  <= '0;
      lk_rsp_valid <= 1'b0;
      lk_hit       <= 1'b0;
      lk_intid     <= '0;
      lk_target    <= '0;
    end else begin
      lk_rsp_valid <= lk_valid;
      lk_hit       <= lk_valid && l_hit;
      lk_intid     <= (lk_valid && l_hit) ? ev_pid[l_eix] : 32'd0;
      lk_target    <= (lk_valid && l_hit) ? col_tgt[ev_col[l_eix]] : 32'd0;
      sync_pulse   <= go && op == OP_SYNC;
      if (cmd_valid && bad) err_flag <= 1'b1;
      if (go) begin
        case (op)
          OP_DEV_MAP: begin
            dev_v[d_ix]  <= c_vld;
            dev_sz[d_ix] <= c_sz;
            for (int e = 0; e < NEVT; e++)
              if (e[EIX_W-1:EVT_BITS] == d_ix) ev_v[e] <= 1'b0;
          end
          OP_COL_MAP: begin
            col_v[c_ix]   <= c_vld;
            col_tgt[c_ix] <= c_tgt;
          end
          OP_EVT_MAP: begin
            ev_v[e_ix]   <= 1'b1;
            ev_pid[e_ix] <= c_pid;
            ev_col[e_ix] <= c_ix;
          end
          OP_EVT_MOVE: ev_col[e_ix] <= c_ix;
          OP_EVT_DROP: ev_v[e_ix]   <= 1'b0;
          OP_SYNC:     sync_target  <= c_tgt;
          default: ;
        endcase
      end
    end
  end

  AST_SYNC_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_word[7:0] == 8'h05 |=> sync_pulse && sync_target == $past(cmd_word[175:144])); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag); // R9
  AST_RSP_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> lk_rsp_valid); // R10
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !lk_rsp_valid && !lk_hit); // R10
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    lk_rsp_valid && !lk_hit |-> lk_intid == 32'd0 && lk_target == 32'd0); // R10
  AST_DEV_RANGE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_word[7:0] == 8'h08 && cmd_word[63:32] >= NDEV |=> err_flag); // R2
endmodule

// File: tb/irq_xlate_engine_test.sv
`timescale 1ns/1ps
module irq_xlate_engine_test;
  logic clk = 0, rst_n = 0, cmd_valid = 0, lk_valid = 0;
  logic [255:0] cmd_word = '0;
  logic [31:0] lk_dev = 0, lk_evt = 0;
  logic lk_rsp_valid, lk_hit, sync_pulse, err_flag;
  logic [31:0] lk_intid, lk_target, sync_target;

  always #2.5 clk = ~clk;

  irq_xlate_engine uut (.clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .lk_valid(lk_valid), .lk_dev(lk_dev), .lk_evt(lk_evt), .lk_rsp_valid(lk_rsp_valid),
    .lk_hit(lk_hit), .lk_intid(lk_intid), .lk_target(lk_target), .sync_pulse(sync_pulse),
    .sync_target(sync_target), .err_flag(err_flag));

  localparam logic [7:0] DMAP = 8'h08, CMAP = 8'h09, EMAP = 8'h0B, EMOV = 8'h01,
                         EDROP = 8'h0F, INV1 = 8'h0C, INVC = 8'h0D, SYNC = 8'h05;
  localparam logic [31:0] T1 = 32'h0001_2345, T2 = 32'h00C0_FFEE, PID = 32'h2000_0040;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  bit q_hit[$];
  logic [31:0] q_int[$], q_tgt[$];
  string q_tag[$];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [255:0] mk(input logic [7:0] op, input logic [31:0] dev, evt, pid,
                                      input logic [4:0] sz, input logic [15:0] col,
                                      input logic [31:0] tgt, input bit vld);
    logic [63:0] d0, d1, d2;
    d0 = {dev, 24'd0, op};
    d1 = {pid, evt};
    d1[4:0] = d1[4:0] | sz;
    d2 = {vld, 15'd0, tgt, col};
    return {64'd0, d2, d1, d0};
  endfunction

  task automatic send(input logic [255:0] w);
    @(negedge clk); cmd_valid = 1; cmd_word = w;
    @(negedge clk); cmd_valid = 0;
  endtask

  task automatic push(input bit h, input logic [31:0] i, t, input string tag);
    q_hit.push_back(h); q_int.push_back(i); q_tgt.push_back(t); q_tag.push_back(tag);
  endtask

  task automatic lookup(input logic [31:0] d, e, input bit h, input logic [31:0] i, t, input string tag);
    @(negedge clk); lk_valid = 1; lk_dev = d; lk_evt = e; push(h, i, t, tag);
    @(negedge clk); lk_valid = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; cmd_valid = 0; lk_valid = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  // monitor: pops expected lookup results
  always @(negedge clk) begin
    if (rst_n && lk_rsp_valid) begin
      if (q_hit.size() == 0) chk(0, "R10 unexpected response", 32'(lk_hit), 0);
      else begin
        bit h; logic [31:0] i, t; string tag;
        h = q_hit.pop_front(); i = q_int.pop_front(); t = q_tgt.pop_front(); tag = q_tag.pop_front();
        chk(lk_hit == h, {tag, " hit"}, 32'(lk_hit), 32'(h));
        chk(lk_intid == i, {tag, " intid"}, lk_intid, i);
        chk(lk_target == t, {tag, " target"}, lk_target, t);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 100000);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    do_reset();
    // R12 reset state
    chk(err_flag === 1'b0, "R12 err", 32'(err_flag), 0);
    chk(sync_pulse === 1'b0, "R12 sync", 32'(sync_pulse), 0);
    chk(lk_rsp_valid === 1'b0, "R12 rsp", 32'(lk_rsp_valid), 0);
    lookup(0, 0, 0, 0, 0, "R12 empty");

    send(mk(CMAP, 0, 0, 0, 0, 2, T1, 1));
    send(mk(DMAP, 3, 0, 0, 2, 0, 0, 1));           // 8 slots
    chk(err_flag == 0, "R2 map ok", 32'(err_flag), 0);
    send(mk(EMAP, 3, 5, PID, 0, 2, 0, 0));
    lookup(3, 5, 1, PID, T1, "R1 R4 R10 hit");
    lookup(3, 6, 0, 0, 0, "R10 unmapped event");
    lookup(4, 5, 0, 0, 0, "R10 unmapped device");
    lookup(3, 32'h100, 0, 0, 0, "R10 beyond size");
    lookup(9, 5, 0, 0, 0, "R10 device out of range");
    send(mk(EMAP, 3, 7, PID + 1, 0, 2, 0, 0));     // last slot
    lookup(3, 7, 1, PID + 1, T1, "R4 last slot");
    chk(err_flag == 0, "R4 no error", 32'(err_flag), 0);

    send(mk(INV1, 3, 5, 0, 0, 0, 0, 0));
    send(mk(INVC, 0, 0, 0, 0, 2, 0, 0));
    chk(err_flag == 0, "R7 no error", 32'(err_flag), 0);
    lookup(3, 5, 1, PID, T1, "R7 unchanged");

    send(mk(CMAP, 0, 0, 0, 0, 5, T2, 1));
    send(mk(EMOV, 3, 5, 0, 0, 5, 0, 0));
    lookup(3, 5, 1, PID, T2, "R5 moved");
    lookup(3, 7, 1, PID + 1, T1, "R5 other kept");

    send(mk(SYNC, 0, 0, 0, 0, 0, 32'hABCD_0123, 0));
    chk(sync_pulse === 1'b1, "R8 pulse", 32'(sync_pulse), 1);
    chk(sync_target == 32'hABCD_0123, "R8 target", sync_target, 32'hABCD_0123);
    @(negedge clk);
    chk(sync_pulse === 1'b0, "R8 one cycle", 32'(sync_pulse), 0);

    send(mk(EDROP, 3, 7, 0, 0, 0, 0, 0));
    lookup(3, 7, 0, 0, 0, "R6 dropped");
    chk(err_flag == 0, "R6 no error", 32'(err_flag), 0);

    send(mk(CMAP, 0, 0, 0, 0, 5, T2, 0));
    lookup(3, 5, 0, 0, 0, "R3 collection unbound");

    // R11 same-cycle command and lookup
    @(negedge clk);
    cmd_valid = 1; cmd_word = mk(CMAP, 0, 0, 0, 0, 5, T2, 1);
    lk_valid = 1; lk_dev = 3; lk_evt = 5; push(0, 0, 0, "R11 old view");
    @(negedge clk); cmd_valid = 0; lk_valid = 0;
    lookup(3, 5, 1, PID, T2, "R11 new view");

    send(mk(DMAP, 3, 0, 0, 2, 0, 0, 0));
    lookup(3, 5, 0, 0, 0, "R2 device unmapped");
    send(mk(DMAP, 3, 0, 0, 2, 0, 0, 1));
    lookup(3, 5, 0, 0, 0, "R2 events cleared");
    chk(err_flag == 0, "R2 no error", 32'(err_flag), 0);

    send(mk(EMAP, 3, 8, PID, 0, 2, 0, 0));
    chk(err_flag == 1, "R4 slot overflow error", 32'(err_flag), 1);
    lookup(3, 8, 0, 0, 0, "R4 not mapped");

    do_reset();
    send(mk(DMAP, 3, 0, 0, 2, 0, 0, 1));
    send(mk(EDROP, 3, 1, 0, 0, 0, 0, 0));
    chk(err_flag == 1, "R6 drop unmapped", 32'(err_flag), 1);

    do_reset();
    send(mk(EMOV, 3, 1, 0, 0, 2, 0, 0));
    chk(err_flag == 1, "R5 move unmapped", 32'(err_flag), 1);

    do_reset();
    send(mk(8'h03, 0, 0, 0, 0, 0, 0, 0));
    chk(err_flag == 1, "R9 unknown opcode", 32'(err_flag), 1);
    send(mk(CMAP, 0, 0, 0, 0, 1, T1, 1));
    chk(err_flag == 1, "R9 sticky", 32'(err_flag), 1);

    do_reset();
    send(mk(DMAP, 9, 0, 0, 2, 0, 0, 1));
    chk(err_flag == 1, "R2 device range", 32'(err_flag), 1);

    do_reset();
    send(mk(CMAP, 0, 0, 0, 0, 8, T1, 1));
    chk(err_flag == 1, "R3 collection range", 32'(err_flag), 1);

    repeat (3) @(negedge clk);
    chk(q_hit.size() == 0, "R10 responses outstanding", q_hit.size(), 0);
    finish_run();
  end
endmodule